// File: doc/BRIEF.md
# Dual-Window Masked GPIO Port

This block controls a port of general-purpose pins. Software reaches the same output latch and direction state through two register windows. The legacy window takes whole-word writes. The fast window honours byte strobes and a per-pin mask that hides pins from reads and writes. A mode bit picks which window may change the port. While one window is active, writes to the other are dropped, but the other window can still be read.

Each pin also has a 2-bit function selector. With selector 00 the pin is plain GPIO: its output value comes from the latch and its output enable from the direction register. Any other code hands the pin to one of three alternate functions, whose value and enable arrive on dedicated input vectors.

Requests arrive on a valid/ready channel. `req_ready` is tied high, so the block never applies back-pressure and takes a request in every cycle where `req_valid` is high. A read answers exactly one cycle later with a one-cycle `rsp_valid` pulse. The response channel has no ready, so the requester must accept it. A write produces no response.

Top module: `gpio_dp_port`

## Requirements
- R1: After reset the output latch, direction, mask, mode bit and all function selectors are zero. `pin_oe` is therefore all zero.
- R2: `req_ready` is always 1. A read accepted at a clock edge raises `rsp_valid` for one cycle after that edge, and `rsp_rdata` then holds the register value at the accepting edge. A write produces no `rsp_valid`.
- R3: Writing 1 to a bit of a set register raises that latch bit, and writing 1 to a bit of a clear register lowers it. Zero bits leave the latch unchanged, and no bit ever moves the other way.
- R4: The legacy window has four registers: 0x00 pin value, 0x04 set, 0x08 direction and 0x0C clear.
  - Reading 0x00 returns the live `pins_in`. A write to 0x00 loads the latch.
  - Reading 0x04 returns the latch, and reading 0x08 returns the direction register.
  - 0x0C reads as 0.
  - Legacy writes ignore `req_be` and update all 32 bits.
- R5: The mode register at 0x40, bit 0, selects the window. With 0 only the legacy window writes port state; with 1 only the fast window does. Configuration registers are writable in either mode.
- R6: In the fast window, writes to pin value, set or clear leave every pin with mask bit 1 unchanged. A fast pin-value read returns 0 on masked bits.
- R7: Fast-window writes update only the bytes whose `req_be` bit is 1. Byte k covers data bits 8k+7..8k.
- R8: The fast window sits at base 0x20, with direction at +0x00, mask at +0x10, pin value at +0x14, set at +0x18 and clear at +0x1C. Clear reads as 0, set reads the latch, and the direction and mask registers read back as stored.
- R9: Function selectors sit at 0x44 (pins 0..15) and 0x48 (pins 16..31), with pin i in bits 2(i mod 16)+1..2(i mod 16). Code 00 drives the pin from latch and direction. Code k in 1..3 drives `pin_out[i]` from `alt_out[32(k-1)+i]` and `pin_oe[i]` from `alt_oe[32(k-1)+i]`.
- R10: A write to the inactive window changes no latch, direction or mask bit. Reads from the inactive window return the current shared contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte strobes |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pins_in | input | 32 | Live pin levels |
| pin_out | output | 32 | Pin output value |
| pin_oe | output | 32 | Pin output enable |
| alt_out | input | 96 | Output values of alternate functions 1..3 |
| alt_oe | input | 96 | Output enables of alternate functions 1..3 |

## Verification
Directed passes first exercise each window alone. The legacy set and clear runs use overlapping patterns, which separate set from clear from a plain load. The fast passes use a half-masked word and single-byte strobes, which show whether the mask and the strobes are applied separately or mixed up. Mode flips with writes aimed at the wrong window tell real blocking apart from a shared write path. Changing the alternate-function vectors under fixed selectors shows that each code routes the right function and that GPIO pins ignore those vectors. A long random run then mixes every address, strobe pattern and mode against a behavioural model that is checked every cycle.

// File: rtl/gpio_dp_pkg.sv
package gpio_dp_pkg;
  localparam int ADDR_W = 7;

  // legacy window, offsets within the low 5 address bits
  localparam logic [4:0] L_PIN = 5'h00;
  localparam logic [4:0] L_SET = 5'h04;
  localparam logic [4:0] L_DIR = 5'h08;
  localparam logic [4:0] L_CLR = 5'h0C;

  // fast window, offsets within the low 5 address bits
  localparam logic [4:0] F_DIR  = 5'h00;
  localparam logic [4:0] F_MASK = 5'h10;
  localparam logic [4:0] F_PIN  = 5'h14;
  localparam logic [4:0] F_SET  = 5'h18;
  localparam logic [4:0] F_CLR  = 5'h1C;

  // configuration registers, offsets within the low 5 address bits
  localparam logic [4:0] C_MODE  = 5'h00;
  localparam logic [4:0] C_FSEL0 = 5'h04;
  localparam logic [4:0] C_FSEL1 = 5'h08;

  // window chosen by address bits 6:5
  typedef enum logic [1:0] {
    WIN_LEGACY = 2'b00,
    WIN_FAST   = 2'b01,
    WIN_CFG    = 2'b10,
    WIN_NONE   = 2'b11
  } win_e;
endpackage

// File: rtl/gpio_dp_window.sv
module gpio_dp_window
  import gpio_dp_pkg::*;
#(
  parameter int N    = 32,
  parameter bit FAST = 1'b0,
  localparam int BEW = N / 8
) (
  input  logic           wr_en,
  input  logic [4:0]     off,
  input  logic [N-1:0]   wdata,
  input  logic [BEW-1:0] be,
  input  logic [N-1:0]   latch_q,
  input  logic [N-1:0]   dir_q,
  input  logic [N-1:0]   mask_q,
  input  logic [N-1:0]   pins_in,
  output logic [N-1:0]   latch_d,
  output logic [N-1:0]   dir_d,
  output logic [N-1:0]   mask_d,
  output logic [N-1:0]   rdata
);
  generate
    if (FAST) begin : g_fast
      logic [N-1:0] bmask;
      logic [N-1:0] live;
      for (genvar b = 0; b < BEW; b++) begin : g_be
        assign bmask[8*b +: 8] = {8{be[b]}};
      end
      assign live = bmask & ~mask_q;

      always_comb begin
        latch_d = latch_q;
        dir_d   = dir_q;
        mask_d  = mask_q;
        rdata   = '0;
        unique case (off)
          F_DIR: begin
            rdata = dir_q;
            if (wr_en) dir_d = (dir_q & ~bmask) | (wdata & bmask);
          end
          F_MASK: begin
            rdata = mask_q;
            if (wr_en) mask_d = (mask_q & ~bmask) | (wdata & bmask);
          end
          F_PIN: begin
            rdata = pins_in & ~mask_q;
            if (wr_en) latch_d = (latch_q & ~live) | (wdata & live);
          end
          F_SET: begin
            rdata = latch_q;
            if (wr_en) latch_d = latch_q | (wdata & live);
          end
          F_CLR: begin
            if (wr_en) latch_d = latch_q & ~(wdata & live);
          end
          default: ;
        endcase
      end
    end else begin : g_legacy
      always_comb begin
        latch_d = latch_q;
        dir_d   = dir_q;
        mask_d  = mask_q;
        rdata   = '0;
        unique case (off)
          L_PIN: begin
            rdata = pins_in;
            if (wr_en) latch_d = wdata;
          end
          L_SET: begin
            rdata = latch_q;
            if (wr_en) latch_d = latch_q | wdata;
          end
          L_DIR: begin
            rdata = dir_q;
            if (wr_en) dir_d = wdata;
          end
          L_CLR: begin
            if (wr_en) latch_d = latch_q & ~wdata;
          end
          default: ;
        endcase
      end
      logic unused_be;
      assign unused_be = ^be;
    end
  endgenerate
endmodule

// File: rtl/gpio_dp_pinmux.sv
module gpio_dp_pinmux #(
  parameter int N    = 32,
  parameter int SELW = 2,
  localparam int NALT = (1 << SELW) - 1
) (
  input  logic [SELW*N-1:0] fsel,
  input  logic [N-1:0]      latch_q,
  input  logic [N-1:0]      dir_q,
  input  logic [NALT*N-1:0] alt_out,
  input  logic [NALT*N-1:0] alt_oe,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [SELW-1:0] sel;
    assign sel = fsel[SELW*i +: SELW];
    always_comb begin
      pin_out[i] = latch_q[i];
      pin_oe[i]  = dir_q[i];
      for (int k = 1; k <= NALT; k++) begin
        if (sel == SELW'(k)) begin
          pin_out[i] = alt_out[(k-1)*N + i];
          pin_oe[i]  = alt_oe[(k-1)*N + i];
        end
      end
    end
  end
endmodule

// File: rtl/gpio_dp_port.sv
module gpio_dp_port
  import gpio_dp_pkg::*;
#(
  parameter int N    = 32,
  parameter int SELW = 2,
  localparam int BEW  = N / 8,
  localparam int NALT = (1 << SELW) - 1,
  localparam int FSW  = SELW * N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [N-1:0]      req_wdata,
  input  logic [BEW-1:0]    req_be,
  output logic              rsp_valid,
  output logic [N-1:0]      rsp_rdata,
  input  logic [N-1:0]      pins_in,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe,
  input  logic [NALT*N-1:0] alt_out,
  input  logic [NALT*N-1:0] alt_oe
);
  logic [N-1:0]   latch_q, dir_q, mask_q;
  logic [FSW-1:0] fsel_q;
  logic           mode_q;

  win_e       win;
  logic [4:0] off;
  logic       wr_acc;
  assign win       = win_e'(req_addr[6:5]);
  assign off       = req_addr[4:0];
  assign wr_acc    = req_valid && req_write;
  assign req_ready = 1'b1;

  logic         leg_wr, fst_wr;
  logic [N-1:0] leg_latch, leg_dir, leg_mask, leg_rd;
  logic [N-1:0] fst_latch, fst_dir, fst_mask, fst_rd;
  assign leg_wr = wr_acc && (win == WIN_LEGACY) && !mode_q;
  assign fst_wr = wr_acc && (win == WIN_FAST) && mode_q;

  gpio_dp_window #(.N(N), .FAST(1'b0)) u_leg (
    .wr_en(leg_wr), .off(off), .wdata(req_wdata), .be(req_be),
    .latch_q(latch_q), .dir_q(dir_q), .mask_q(mask_q), .pins_in(pins_in),
    .latch_d(leg_latch), .dir_d(leg_dir), .mask_d(leg_mask), .rdata(leg_rd)
  );

  gpio_dp_window #(.N(N), .FAST(1'b1)) u_fst (
    .wr_en(fst_wr), .off(off), .wdata(req_wdata), .be(req_be),
    .latch_q(latch_q), .dir_q(dir_q), .mask_q(mask_q), .pins_in(pins_in),
    .latch_d(fst_latch), .dir_d(fst_dir), .mask_d(fst_mask), .rdata(fst_rd)
  );

  // configuration registers: strobe-aware, writable in either mode
  logic [N-1:0] bmask;
  for (genvar b = 0; b < BEW; b++) begin : g_cbe
    assign bmask[8*b +: 8] = {8{req_be[b]}};
  end

  logic           cfg_wr;
  logic [FSW-1:0] fsel_d;
  logic           mode_d;
  logic [N-1:0]   cfg_rd;
  assign cfg_wr = wr_acc && (win == WIN_CFG);

  always_comb begin
    fsel_d = fsel_q;
    mode_d = mode_q;
    cfg_rd = '0;
    unique case (off)
      C_MODE: begin
        cfg_rd[0] = mode_q;
        if (cfg_wr && req_be[0]) mode_d = req_wdata[0];
      end
      C_FSEL0: begin
        cfg_rd = fsel_q[N-1:0];
        if (cfg_wr) fsel_d[N-1:0] = (fsel_q[N-1:0] & ~bmask) | (req_wdata & bmask);
      end
      C_FSEL1: begin
        cfg_rd = fsel_q[FSW-1:N];
        if (cfg_wr) fsel_d[FSW-1:N] = (fsel_q[FSW-1:N] & ~bmask) | (req_wdata & bmask);
      end
      default: ;
    endcase
  end

  logic [N-1:0] rd_mux;
  always_comb begin
    unique case (win)
      WIN_LEGACY: rd_mux = leg_rd;
      WIN_FAST:   rd_mux = fst_rd;
      WIN_CFG:    rd_mux = cfg_rd;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q   <= '0;
      dir_q     <= '0;
      mask_q    <= '0;
      fsel_q    <= '0;
      mode_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (mode_q) begin
        latch_q <= fst_latch;
        dir_q   <= fst_dir;
        mask_q  <= fst_mask;
      end else begin
        latch_q <= leg_latch;
        dir_q   <= leg_dir;
        mask_q  <= leg_mask;
      end
      fsel_q    <= fsel_d;
      mode_q    <= mode_d;
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_mux;
    end
  end

  gpio_dp_pinmux #(.N(N), .SELW(SELW)) u_mux (
    .fsel(fsel_q), .latch_q(latch_q), .dir_q(dir_q),
    .alt_out(alt_out), .alt_oe(alt_oe), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // response channel behaviour
  p_read_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  p_write_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> !rsp_valid);

  // set only raises, clear only lowers
  p_set_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (leg_wr && off == L_SET) |=> (($past(latch_q) & ~latch_q) == '0));
  p_clr_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (leg_wr && off == L_CLR) |=> ((latch_q & ~$past(latch_q)) == '0));

  // masked pins untouched by fast latch writes
  p_mask_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fst_wr && (off == F_PIN || off == F_SET || off == F_CLR))
      |=> (((latch_q ^ $past(latch_q)) & $past(mask_q)) == '0));

  // writes to the inactive window change nothing
  p_idle_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && ((win == WIN_LEGACY && mode_q) || (win == WIN_FAST && !mode_q)))
      |=> ($stable(latch_q) && $stable(dir_q) && $stable(mask_q)));
endmodule

// File: tb/gpio_dp_port_tb_top.sv
module gpio_dp_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [6:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [31:0] pins_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic [95:0] alt_out = '0, alt_oe = '0;

  always #10 clk = ~clk;

  gpio_dp_port dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .pins_in(pins_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .alt_out(alt_out), .alt_oe(alt_oe)
  );

  int    n_checks = 0, n_errs = 0;
  bit    done = 0;
  string cur_tag = "R1";

  // behavioural reference
  bit [31:0] m_latch = 0, m_dir = 0, m_mask = 0;
  bit        m_mode = 0;
  int        m_sel [32];
  bit        exp_rv = 0;
  bit [31:0] exp_rd = 0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit [31:0] sel_word(int base);
    bit [31:0] w = 0;
    for (int i = 0; i < 16; i++) begin
      w[2*i]   = m_sel[base+i][0];
      w[2*i+1] = m_sel[base+i][1];
    end
    return w;
  endfunction

  function automatic bit [31:0] model_read(bit [6:0] a);
    case (a)
      7'h00: return pins_in;
      7'h04: return m_latch;
      7'h08: return m_dir;
      7'h20: return m_dir;
      7'h30: return m_mask;
      7'h34: return pins_in & ~m_mask;
      7'h38: return m_latch;
      7'h40: return {31'b0, m_mode};
      7'h44: return sel_word(0);
      7'h48: return sel_word(16);
      default: return 0;
    endcase
  endfunction

  task automatic model_write(bit [6:0] a, bit [31:0] d, bit [3:0] be);
    bit on;
    if (!m_mode) begin
      case (a)
        7'h00: m_latch = d;
        7'h04: m_latch = m_latch | d;
        7'h08: m_dir = d;
        7'h0C: m_latch = m_latch & ~d;
        default: ;
      endcase
    end else begin
      for (int i = 0; i < 32; i++) begin
        if (be[i/8]) begin
          on = !m_mask[i];
          case (a)
            7'h20: m_dir[i] = d[i];
            7'h34: if (on) m_latch[i] = d[i];
            7'h38: if (on && d[i]) m_latch[i] = 1'b1;
            7'h3C: if (on && d[i]) m_latch[i] = 1'b0;
            default: ;
          endcase
        end
      end
      if (a == 7'h30)
        for (int i = 0; i < 32; i++) if (be[i/8]) m_mask[i] = d[i];
    end
    if (a == 7'h40 && be[0]) m_mode = d[0];
    if (a == 7'h44 || a == 7'h48)
      for (int i = 0; i < 16; i++)
        if (be[(2*i)/8]) m_sel[(a == 7'h48 ? 16 : 0) + i] = int'(d[2*i +: 2]);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      exp_rv = req_valid && !req_write;
      if (exp_rv) exp_rd = model_read(req_addr);
      if (req_valid && req_write) model_write(req_addr, req_wdata, req_be);
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit [31:0] eo = 0, ee = 0;
      for (int i = 0; i < 32; i++) begin
        if (m_sel[i] == 0) begin
          eo[i] = m_latch[i]; ee[i] = m_dir[i];
        end else begin
          eo[i] = alt_out[(m_sel[i]-1)*32 + i]; ee[i] = alt_oe[(m_sel[i]-1)*32 + i];
        end
      end
      check(cur_tag, "pin_out (R9)", pin_out, eo);
      check(cur_tag, "pin_oe (R9)", pin_oe, ee);
      check(cur_tag, "rsp_valid (R2)", {31'b0, rsp_valid}, {31'b0, exp_rv});
      check(cur_tag, "req_ready (R2)", {31'b0, req_ready}, 32'd1);
      if (exp_rv && rsp_valid) check(cur_tag, "rsp_rdata", rsp_rdata, exp_rd);
    end
  end

  task automatic wr(bit [6:0] a, bit [31:0] d, bit [3:0] be = 4'hF);
    @(negedge clk); #1;
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = be;
  endtask
  task automatic rd(bit [6:0] a);
    @(negedge clk); #1;
    req_valid = 1; req_write = 0; req_addr = a; req_wdata = $urandom; req_be = 4'hF;
  endtask
  task automatic idle(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      req_valid = 0; req_write = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_errs++; n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    bit [6:0] alist [12] = '{7'h00, 7'h04, 7'h08, 7'h0C, 7'h20, 7'h30,
                             7'h34, 7'h38, 7'h3C, 7'h40, 7'h44, 7'h48};
    foreach (m_sel[i]) m_sel[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", "pin_oe after reset", pin_oe, 32'h0);
    check("R1", "pin_out after reset", pin_out, 32'h0);
    cur_tag = "R1"; rd(7'h08); rd(7'h30); rd(7'h40); rd(7'h44); rd(7'h48); idle(2);

    // R4 legacy map, R3 set/clear
    cur_tag = "R4"; pins_in = 32'h1234_5678;
    wr(7'h08, 32'hFFFF_00FF, 4'h1); rd(7'h08); rd(7'h00);
    cur_tag = "R3";
    wr(7'h04, 32'hA5A5_A5A5); rd(7'h04); wr(7'h04, 32'h0); rd(7'h04);
    wr(7'h0C, 32'h0000_FFFF); rd(7'h04); wr(7'h0C, 32'h0); rd(7'h0C);
    cur_tag = "R4"; wr(7'h00, 32'hCAFE_F00D, 4'h2); rd(7'h04); idle(2);

    // R10 and R5: fast window blocked while mode is 0
    cur_tag = "R10"; wr(7'h38, 32'hFFFF_FFFF); wr(7'h30, 32'hFFFF_FFFF);
    wr(7'h20, 32'h0); rd(7'h38); rd(7'h30); rd(7'h20);
    cur_tag = "R5"; wr(7'h40, 32'h1); rd(7'h40);
    cur_tag = "R10"; wr(7'h04, 32'hFFFF_FFFF); wr(7'h08, 32'h0); wr(7'h00, 32'h0);
    rd(7'h04); rd(7'h08); rd(7'h00); idle(2);

    // R8 fast map, R6 mask, R7 strobes
    cur_tag = "R8"; wr(7'h20, 32'h0F0F_0F0F); rd(7'h20); rd(7'h3C);
    cur_tag = "R6"; wr(7'h30, 32'hFF00_FF00); rd(7'h30);
    wr(7'h38, 32'hFFFF_FFFF); rd(7'h38); wr(7'h3C, 32'hFFFF_FFFF); rd(7'h38);
    wr(7'h34, 32'h5A5A_5A5A); rd(7'h38); pins_in = 32'hDEAD_BEEF; rd(7'h34);
    cur_tag = "R7"; wr(7'h30, 32'h0, 4'h2); rd(7'h30); wr(7'h20, 32'hFFFF_FFFF, 4'h4);
    rd(7'h20); wr(7'h38, 32'hFFFF_FFFF, 4'h8); rd(7'h38); wr(7'h3C, 32'hFFFF_FFFF, 4'h2);
    rd(7'h38); idle(2);

    // R9 function select routing
    cur_tag = "R9";
    alt_out = {32'hF0F0_F0F0, 32'h3333_3333, 32'hAAAA_AAAA};
    alt_oe  = {32'h0F0F_0F0F, 32'hCCCC_CCCC, 32'h5555_5555};
    wr(7'h44, 32'h0000_0801); wr(7'h48, 32'h4000_000C); rd(7'h44); rd(7'h48);
    idle(1); alt_out = ~alt_out; alt_oe = ~alt_oe; idle(2);
    wr(7'h44, 32'hFFFF_FFFF, 4'h1); idle(2);

    // mixed random traffic
    cur_tag = "R10";
    for (int k = 0; k < 600; k++) begin
      bit [6:0] a = alist[$urandom_range(0, 11)];
      if (k % 37 == 0) pins_in = $urandom;
      if (k % 53 == 0) begin alt_out = {$urandom, $urandom, $urandom}; alt_oe = {$urandom, $urandom, $urandom}; end
      if ($urandom_range(0, 2) == 0) rd(a);
      else wr(a, $urandom, 4'($urandom_range(0, 15)));
      if ($urandom_range(0, 5) == 0) idle(1);
    end
    idle(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule